// File: doc/BRIEF.md
# Sync-Aligned Converter Clock Regenerator

At each receiving node, this block rebuilds a converter clock and a sync strobe from a distributed master clock and a raw sync line. Every node sees the same master clock. Each node recognises an incoming sync event on the same active (rising) master clock edge. That event forces the local clock divider back to phase zero. As a result, whatever phase error a node has built up against its neighbours is gone by the next sync, which arrives at a rate in the kHz range.

The regenerated sync strobe is exactly one master cycle wide. It is launched from the falling (inactive) master edge. At a nominal 24.576 MHz master clock, this keeps every strobe transition about 20 ns away from the rising edge, more than the 10 to 15 ns margin that downstream converters need. A conversion timer counts a fixed number of converter clock periods after each sync and then raises a one-cycle ready flag.

The divide ratio is a parameter. With a ratio of 1, the converter clock is the master clock gated on once the first sync has been accepted, and only the sync retiming and the timer are active.

Top module: `conv_clk_realigner`

## Requirements
- R1: During reset, and after reset until the first accepted sync event, `div_clk`, `sync_out` and `conv_ready` are low and the divider does not advance.
- R2: `sync_in` passes through a two-stage synchronizer on the rising edge followed by rising-edge detection. A high level on `sync_in` that is set up before rising edge k is accepted as one event at edge k+2. A high pulse of any length yields exactly one event.
- R3: An accepted event restarts the divider at phase zero on its edge. For DIV_RATIO = N ≥ 2, `div_clk` is then high for N/2 master cycles and low for the remaining N − N/2, repeating.
- R4: `sync_out` rises on the falling edge that follows the event edge. It stays high for exactly one master clock cycle and never changes on a rising edge.
- R5: Every accepted event restarts the conversion timer and clears a pending count, so a ready flag due from the earlier sync does not appear.
- R6: `conv_ready` is high for exactly one master cycle. It goes high after the rising edge that comes READY_CYCLES × DIV_RATIO edges after the event edge (READY_CYCLES defaults to 1024).
- R7: An event whose edge coincides with the divider's natural wrap to phase zero leaves the `div_clk` waveform unchanged: no glitch, no stretched or shortened level.
- R8: With DIV_RATIO = 1, `div_clk` follows `clk` once the first event has been accepted, and stays low before that.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Distributed master clock; rising edge is the active edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_in | input | 1 | Raw distributed sync line, asynchronous to `clk` |
| div_clk | output | 1 | Regenerated converter clock |
| sync_out | output | 1 | Retimed one-cycle sync strobe, launched on the falling edge |
| conv_ready | output | 1 | One-cycle conversion-ready flag |

## Verification
Some properties are checked by assertions on every cycle:
- the edge detector never produces two events in a row;
- the divider sits at phase zero while idle and right after an event;
- `div_clk` starts high after an event;
- the ready flag lasts one cycle and is cleared by a new sync;
- the falling-edge strobe lasts one cycle;
- the outputs are quiet during reset.

Other behaviours only the directed scenarios can show:
- the exact edge on which an event takes effect;
- the full `div_clk` waveform across an in-phase and an out-of-phase resync;
- the precise cycle on which `conv_ready` fires;
- the suppression of a stale ready;
- the passthrough mode at a ratio of 1.

// File: rtl/ccr_pkg.sv
package ccr_pkg;

  // Converter clock level for a given divider phase: high for the first half.
  function automatic logic div_level(input int unsigned phase, input int unsigned ratio);
    return phase < (ratio / 2);
  endfunction

  // Next divider phase, wrapping at ratio-1.
  function automatic int unsigned phase_next(input int unsigned phase, input int unsigned ratio);
    return (phase + 1 >= ratio) ? 0 : phase + 1;
  endfunction

  // Master clock edges from sync event to ready flag.
  function automatic int unsigned ready_edges(input int unsigned periods, input int unsigned ratio);
    return periods * ratio;
  endfunction

endpackage

// File: rtl/ccr_sync_in.sv
module ccr_sync_in #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sync_raw,
  output logic sync_evt
);
  logic [STAGES-1:0] meta_q;
  logic              prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      prev_q <= 1'b0;
    end else begin
      meta_q <= {meta_q[STAGES-2:0], sync_raw};
      prev_q <= meta_q[STAGES-1];
    end
  end

  assign sync_evt = meta_q[STAGES-1] & ~prev_q;

  AST_EVT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    sync_evt |=> !sync_evt); // R2

endmodule

// File: rtl/ccr_divider.sv
module ccr_divider #(
  parameter int unsigned RATIO = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sync_evt,
  output logic div_clk,
  output logic conv_tick
);
  import ccr_pkg::*;

  localparam int unsigned PW   = (RATIO > 1) ? $clog2(RATIO) : 1;
  localparam int unsigned LAST = RATIO - 1;

  logic [PW-1:0] ph_q;
  logic [PW-1:0] ph_nxt;
  logic          run_q;

  assign ph_nxt    = PW'(phase_next(int'(ph_q), RATIO));
  // A converter period completes at the edge where the phase wraps naturally.
  assign conv_tick = run_q && !sync_evt && (ph_q == PW'(LAST));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= '0;
      run_q <= 1'b0;
    end else if (sync_evt) begin
      ph_q  <= '0;
      run_q <= 1'b1;
    end else if (run_q) begin
      ph_q  <= ph_nxt;
    end
  end

  generate
    if (RATIO == 1) begin : g_pass
      assign div_clk = clk & run_q;
    end else begin : g_div
      logic div_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        div_q <= 1'b0;
        else if (sync_evt) div_q <= div_level(0, RATIO);
        else if (run_q)    div_q <= div_level(int'(ph_nxt), RATIO);
      end
      assign div_clk = div_q;

      AST_DIV_HIGH_AFTER_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
        sync_evt |=> div_q); // R3
      AST_DIV_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !run_q |-> !div_q); // R1
    end
  endgenerate

  AST_PH_ZERO_AFTER_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    sync_evt |=> (ph_q == '0)); // R3
  AST_PH_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |-> (ph_q == '0)); // R1

endmodule

// File: rtl/ccr_ready_timer.sv
module ccr_ready_timer #(
  parameter int unsigned PERIODS = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sync_evt,
  input  logic conv_tick,
  output logic conv_ready
);
  localparam int unsigned CW = (PERIODS > 1) ? $clog2(PERIODS) : 1;
  localparam logic [CW-1:0] LAST = CW'(PERIODS - 1);

  logic [CW-1:0] cnt_q;
  logic          armed_q;
  logic          ready_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
      ready_q <= 1'b0;
    end else if (sync_evt) begin
      cnt_q   <= '0;
      armed_q <= 1'b1;
      ready_q <= 1'b0;
    end else if (armed_q && conv_tick) begin
      if (cnt_q == LAST) begin
        cnt_q   <= '0;
        armed_q <= 1'b0;
        ready_q <= 1'b1;
      end else begin
        cnt_q   <= cnt_q + 1'b1;
        ready_q <= 1'b0;
      end
    end else begin
      ready_q <= 1'b0;
    end
  end

  assign conv_ready = ready_q;

  AST_READY_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    conv_ready |=> !conv_ready); // R6
  AST_READY_CLEARED_BY_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    sync_evt |=> !conv_ready); // R5

endmodule

// File: rtl/conv_clk_realigner.sv
module conv_clk_realigner #(
  parameter int unsigned DIV_RATIO    = 1,
  parameter int unsigned READY_CYCLES = 1024,
  parameter int unsigned SYNC_STAGES  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sync_in,
  output logic div_clk,
  output logic sync_out,
  output logic conv_ready
);
  logic sync_evt;
  logic conv_tick;
  logic launch_q;
  logic strobe_q;

  ccr_sync_in #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .sync_raw (sync_in),
    .sync_evt (sync_evt)
  );

  ccr_divider #(.RATIO(DIV_RATIO)) u_div (
    .clk       (clk),
    .rst_n     (rst_n),
    .sync_evt  (sync_evt),
    .div_clk   (div_clk),
    .conv_tick (conv_tick)
  );

  ccr_ready_timer #(.PERIODS(READY_CYCLES)) u_ready (
    .clk        (clk),
    .rst_n      (rst_n),
    .sync_evt   (sync_evt),
    .conv_tick  (conv_tick),
    .conv_ready (conv_ready)
  );

  // Event captured on the active edge, relaunched half a cycle later.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) launch_q <= 1'b0;
    else        launch_q <= sync_evt;
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) strobe_q <= 1'b0;
    else        strobe_q <= launch_q;
  end

  assign sync_out = strobe_q;

  AST_STROBE_ONE_CYCLE: assert property (@(negedge clk) disable iff (!rst_n)
    sync_out |=> !sync_out); // R4
  AST_STROBE_FOLLOWS_LAUNCH: assert property (@(negedge clk) disable iff (!rst_n)
    launch_q |-> ##0 1'b1 ##1 sync_out); // R4
  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |-> (!conv_ready && !sync_out)); // R1

endmodule

// File: tb/conv_clk_realigner_tb.sv
module conv_clk_realigner_tb;
  localparam int unsigned RATIO   = 4;
  localparam int unsigned PERIODS = 1024;
  localparam int unsigned RDY     = PERIODS * RATIO;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sync_in = 1'b0;
  logic div_clk, sync_out, conv_ready;
  logic div1, sync1, rdy1;

  int total = 0;
  int bad = 0;
  int rises = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  conv_clk_realigner #(.DIV_RATIO(RATIO), .READY_CYCLES(PERIODS)) u_dut (
    .clk(clk), .rst_n(rst_n), .sync_in(sync_in),
    .div_clk(div_clk), .sync_out(sync_out), .conv_ready(conv_ready));

  conv_clk_realigner #(.DIV_RATIO(1), .READY_CYCLES(4)) u_dut_r1 (
    .clk(clk), .rst_n(rst_n), .sync_in(sync_in),
    .div_clk(div1), .sync_out(sync1), .conv_ready(rdy1));

  always @(posedge sync_out) rises++;

  task automatic chk(input logic act, input logic exp, input string req);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  // One-cycle sync pulse; returns just after the edge on which it is accepted.
  task automatic fire();
    @(negedge clk) sync_in = 1'b1;
    @(negedge clk) sync_in = 1'b0;
    repeat (2) @(posedge clk);
  endtask

  task automatic t_reset();
    #2;
    chk(div_clk, 1'b0, "R1 div_clk in reset");
    chk(sync_out, 1'b0, "R1 sync_out in reset");
    chk(conv_ready, 1'b0, "R1 conv_ready in reset");
    @(negedge clk) rst_n = 1'b1;
    repeat (10) @(posedge clk);
    #1;
    chk(div_clk, 1'b0, "R1 div_clk idle before sync");
    chk(div1, 1'b0, "R8 ratio-1 clock idle before sync");
    chk(conv_ready, 1'b0, "R1 ready idle before sync");
  endtask

  task automatic t_long_pulse();
    int r0;
    r0 = rises;
    @(negedge clk) sync_in = 1'b1;
    repeat (9) @(negedge clk);
    sync_in = 1'b0;
    repeat (6) @(negedge clk);
    total++;
    if (rises - r0 != 1) begin
      bad++;
      $display("FAIL R2 long pulse: actual=%0d expected=1 strobes", rises - r0);
    end
  endtask

  task automatic t_first_sync();
    fire();
    #1;
    chk(div_clk, 1'b1, "R3 div_clk high at phase zero");
    chk(sync_out, 1'b0, "R4 strobe not on active edge");
    chk(div1, 1'b1, "R8 ratio-1 follows clk high");
    @(negedge clk) #1;
    chk(sync_out, 1'b1, "R4 strobe on falling edge");
    chk(div1, 1'b0, "R8 ratio-1 follows clk low");
    chk(div_clk, 1'b1, "R3 div_clk high second cycle");
    @(negedge clk) #1;
    chk(sync_out, 1'b0, "R4 strobe one cycle wide");
    repeat (RDY - 2) @(posedge clk);
    #1 chk(conv_ready, 1'b0, "R6 ready not early");
    @(posedge clk) #1 chk(conv_ready, 1'b1, "R6 ready on time");
    @(posedge clk) #1 chk(conv_ready, 1'b0, "R6 ready one cycle");
  endtask

  task automatic t_inphase();
    fire();
    fork
      begin
        repeat (5) @(posedge clk);
        fire();
      end
      begin
        for (int j = 1; j <= 20; j++) begin
          @(posedge clk) #1;
          chk(div_clk, logic'((j % RATIO) < RATIO / 2), "R7 in-phase waveform");
        end
      end
    join
    repeat (RDY - 20) @(posedge clk);
    #1 chk(conv_ready, 1'b0, "R5 stale ready suppressed");
    repeat (7) @(posedge clk);
    #1 chk(conv_ready, 1'b0, "R6 ready not early after resync");
    @(posedge clk) #1 chk(conv_ready, 1'b1, "R5 ready from latest sync");
    @(posedge clk) #1 chk(conv_ready, 1'b0, "R6 ready one cycle");
  endtask

  task automatic t_outphase();
    fire();
    fork
      begin
        repeat (3) @(posedge clk);
        fire();
      end
      begin
        for (int j = 1; j <= 14; j++) begin
          int k;
          k = (j < 6) ? j : j - 6;
          @(posedge clk) #1;
          chk(div_clk, logic'((k % RATIO) < RATIO / 2), "R3 out-of-phase realign");
        end
      end
    join
  endtask

  initial begin
    t_reset();
    t_long_pulse();
    t_first_sync();
    t_inphase();
    t_outphase();
    if (!finished) begin
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule